// File: doc/BRIEF.md
# Token-Ordered Completion Buffer

This block restores arrival order for work that finishes out of order. A client first takes a tag from the buffer, and only then starts its work. When the work completes, the client writes its result under that tag. Results may come back in any order. A consumer reads results out strictly in the order the tags were issued. Each read waits until the oldest outstanding result has actually been written.

The buffer keeps a ring of slots. Each slot has a result register and a valid flag. A write pointer issues tags, and a read pointer names the oldest outstanding slot. An occupancy counter tracks how many tags are outstanding.

A three-state occupancy machine gates both ends:
- `OCC_EMPTY`: no tag is outstanding.
- `OCC_BUSY`: some tags are outstanding and at least one slot is free.
- `OCC_FULL`: every slot holds an outstanding tag.

The machine has four transitions:
- EMPTY→BUSY happens on an allocation.
- BUSY→FULL happens on an allocation that is not paired with a drain while one slot is free.
- BUSY→EMPTY happens on a drain that is not paired with an allocation while one tag is outstanding.
- FULL→BUSY happens on a drain.

An allocation and a drain in the same cycle leave the state and the count unchanged.

Top module: `cmpl_reorder_buf`

## Requirements
- R1: After reset, `alloc_ok` is 1, `drain_ok` is 0, `alloc_tag` is 0, and no tag is outstanding.
- R2: An allocation fires on a cycle with `alloc_req` and `alloc_ok` both high. It returns the current `alloc_tag`, which is the slot index. Successive tags count up by one and wrap from SLOTS-1 (15 by default) to 0.
- R3: With SLOTS tags outstanding, `alloc_ok` is 0. A request made then is ignored: `alloc_tag` and `alloc_ok` stay unchanged.
- R4: A fill (`fill_en`=1) stores `fill_data` in slot `fill_tag` and marks that slot valid. Fills may arrive in any order.
- R5: `drain_ok` is 1 only when at least one tag is outstanding and the slot at the read pointer is valid. `drain_data` then shows that slot's stored result.
- R6: Drains return results in the order their tags were issued, whatever the order of completion.
- R7: A drain fires on a cycle with `drain_req` and `drain_ok` both high. It advances the read pointer by one, wrapping modulo SLOTS. It lowers the outstanding count by one, so a full buffer accepts an allocation again.
- R8: An allocation and a drain in the same cycle leave the outstanding count unchanged.
- R9: A drain clears the drained slot's valid flag, and an allocation clears the allocated slot's valid flag. A reissued tag is therefore not drainable until it is filled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request a tag |
| alloc_ok | output | 1 | A tag is available this cycle |
| alloc_tag | output | TAG_W (4) | Tag issued if the allocation fires |
| fill_en | input | 1 | Write a result |
| fill_tag | input | TAG_W (4) | Tag the result belongs to |
| fill_data | input | DATA_W (32) | Result value |
| drain_req | input | 1 | Consumer takes the oldest result |
| drain_ok | output | 1 | Oldest result is present |
| drain_data | output | DATA_W (32) | Oldest result value |

## Verification
The bench runs full rounds of SLOTS allocations. Each round fills the slots in one of three orders: issue order, reverse order, or a shuffle from a bench-side generator. These orders tell real reordering apart from plain first-in-first-out behaviour. The reverse round separates a head-valid gate from an any-valid gate. After every fill the bench predicts `drain_ok` from whether the oldest tag has been written yet. A partial round pairs an allocation with a drain at the near-full point, which exposes count errors on the concurrent path. The same round then reissues a drained slot and checks that it is not released before it is refilled.

// File: rtl/cmpl_rob_pkg.sv
package cmpl_rob_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_BUSY  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_e;

endpackage

// File: rtl/cmpl_rob_ctrl.sv
module cmpl_rob_ctrl
    import cmpl_rob_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int TAG_W = $clog2(SLOTS),
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_req,
    input  logic             drain_req,
    input  logic             head_valid,
    output logic             alloc_ok,
    output logic             drain_ok,
    output logic             alloc_fire,
    output logic             drain_fire,
    output logic [TAG_W-1:0] wr_ptr,
    output logic [TAG_W-1:0] rd_ptr
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOTS - 1);
    localparam logic [TAG_W-1:0] PTR_TOP  = TAG_W'(SLOTS - 1);

    occ_state_e       state, state_nx;
    logic [CNT_W-1:0] occ_cnt;

    // outputs decoded from the occupancy state
    always_comb begin
        alloc_ok = 1'b0;
        drain_ok = 1'b0;
        unique case (state)
            OCC_EMPTY: alloc_ok = 1'b1;
            OCC_BUSY: begin
                alloc_ok = 1'b1;
                drain_ok = head_valid;
            end
            OCC_FULL:  drain_ok = head_valid;
            default: ;
        endcase
    end

    assign alloc_fire = alloc_req && alloc_ok;
    assign drain_fire = drain_req && drain_ok;

    always_comb begin
        state_nx = state;
        unique case (state)
            OCC_EMPTY: if (alloc_fire) state_nx = OCC_BUSY;
            OCC_BUSY: begin
                if (alloc_fire && !drain_fire && occ_cnt == CNT_LAST)
                    state_nx = OCC_FULL;
                else if (drain_fire && !alloc_fire && occ_cnt == CNT_ONE)
                    state_nx = OCC_EMPTY;
            end
            OCC_FULL:  if (drain_fire) state_nx = OCC_BUSY;
            default:   state_nx = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= OCC_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_cnt <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
        end else begin
            if (alloc_fire && !drain_fire)      occ_cnt <= occ_cnt + CNT_ONE;
            else if (drain_fire && !alloc_fire) occ_cnt <= occ_cnt - CNT_ONE;
            if (alloc_fire) wr_ptr <= (wr_ptr == PTR_TOP) ? '0 : wr_ptr + 1'b1;
            if (drain_fire) rd_ptr <= (rd_ptr == PTR_TOP) ? '0 : rd_ptr + 1'b1;
        end
    end

    assert_empty_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OCC_EMPTY) == (occ_cnt == '0));
    assert_full_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == OCC_FULL) == (occ_cnt == CNT_W'(SLOTS)));
    assert_wr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && wr_ptr == PTR_TOP) |=> wr_ptr == '0);
    assert_rd_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_fire && rd_ptr == PTR_TOP) |=> rd_ptr == '0);
    assert_cnt_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_fire && !alloc_fire) |=> occ_cnt == $past(occ_cnt) - CNT_ONE);
    assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_fire && alloc_fire) |=> $stable(occ_cnt));

endmodule

// File: rtl/cmpl_rob_flags.sv
module cmpl_rob_flags #(
    parameter int SLOTS = 16,
    localparam int TAG_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic [TAG_W-1:0] wr_ptr,
    input  logic             drain_fire,
    input  logic [TAG_W-1:0] rd_ptr,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    output logic             head_valid
);

    logic [SLOTS-1:0] vld;

    for (genvar s = 0; s < SLOTS; s++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[s] <= 1'b0;
            end else if (fill_en && fill_tag == TAG_W'(s)) begin
                vld[s] <= 1'b1;
            end else if ((alloc_fire && wr_ptr == TAG_W'(s)) ||
                         (drain_fire && rd_ptr == TAG_W'(s))) begin
                vld[s] <= 1'b0;
            end
        end
    end

    assign head_valid = vld[rd_ptr];

    assert_fill_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> vld[$past(fill_tag)]);
    assert_drain_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_fire && !(fill_en && fill_tag == rd_ptr)) |=> !vld[$past(rd_ptr)]);
    assert_alloc_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !(fill_en && fill_tag == wr_ptr)) |=> !vld[$past(wr_ptr)]);

endmodule

// File: rtl/cmpl_rob_store.sv
module cmpl_rob_store #(
    parameter int SLOTS  = 16,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [TAG_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [SLOTS];

    always_ff @(posedge clk) begin
        if (fill_en) mem[fill_tag] <= fill_data;
    end

    assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/cmpl_reorder_buf.sv
module cmpl_reorder_buf #(
    parameter int SLOTS  = 16,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    output logic              alloc_ok,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              drain_req,
    output logic              drain_ok,
    output logic [DATA_W-1:0] drain_data
);

    logic             alloc_fire, drain_fire, head_valid;
    logic [TAG_W-1:0] wr_ptr, rd_ptr;

    cmpl_rob_ctrl #(.SLOTS(SLOTS)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .drain_req(drain_req), .head_valid(head_valid),
        .alloc_ok(alloc_ok), .drain_ok(drain_ok),
        .alloc_fire(alloc_fire), .drain_fire(drain_fire),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
    );

    cmpl_rob_flags #(.SLOTS(SLOTS)) flags_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_fire(alloc_fire), .wr_ptr(wr_ptr),
        .drain_fire(drain_fire), .rd_ptr(rd_ptr),
        .fill_en(fill_en), .fill_tag(fill_tag),
        .head_valid(head_valid)
    );

    cmpl_rob_store #(.SLOTS(SLOTS), .DATA_W(DATA_W)) store_i (
        .clk(clk), .fill_en(fill_en), .fill_tag(fill_tag),
        .fill_data(fill_data), .rd_ptr(rd_ptr), .rd_data(drain_data)
    );

    assign alloc_tag = wr_ptr;

    assert_drain_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drain_ok |-> head_valid);
    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !alloc_ok) |=> $stable(alloc_tag));

endmodule

// File: tb/cmpl_reorder_buf_tb.sv
`timescale 1ns/100ps
module cmpl_reorder_buf_tb_top;

    localparam int SLOTS  = 16;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              alloc_req, fill_en, drain_req;
    logic [TAG_W-1:0]  fill_tag;
    logic [DATA_W-1:0] fill_data;
    logic              alloc_ok, drain_ok;
    logic [TAG_W-1:0]  alloc_tag;
    logic [DATA_W-1:0] drain_data;

    int checks = 0;
    int errors = 0;
    int wr_exp = 0;
    int rd_exp = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    cmpl_reorder_buf #(.SLOTS(SLOTS), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
        .fill_en(fill_en), .fill_tag(fill_tag), .fill_data(fill_data),
        .drain_req(drain_req), .drain_ok(drain_ok), .drain_data(drain_data)
    );

    function automatic logic [DATA_W-1:0] val_of(int rnd, int tag);
        return {8'h5A, 8'(rnd), 12'h0C3, 4'(tag)};
    endfunction

    task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        alloc_req = 1'b0;
        fill_en   = 1'b0;
        drain_req = 1'b0;
        #1;
    endtask

    task automatic lfsr_step();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // one full round: allocate every slot, fill in a chosen order, drain all
    task automatic run_round(int rnd, int mode);
        int order [SLOTS];
        bit done  [SLOTS];
        for (int i = 0; i < SLOTS; i++) begin
            alloc_req = 1'b1;
            #1;
            chk("R2 tag", 32'(alloc_tag), 32'(wr_exp));
            chk("R3 ok before full", 32'(alloc_ok), 32'd1);
            tick();
            wr_exp = (wr_exp + 1) % SLOTS;
        end
        chk("R3 full", 32'(alloc_ok), 32'd0);
        alloc_req = 1'b1;
        tick();
        chk("R3 ignored tag", 32'(alloc_tag), 32'(wr_exp));
        chk("R3 ignored ok", 32'(alloc_ok), 32'd0);
        for (int i = 0; i < SLOTS; i++) begin
            order[i] = (rd_exp + i) % SLOTS;
            done[i]  = 1'b0;
        end
        if (mode == 1) begin
            for (int i = 0; i < SLOTS; i++) order[i] = (rd_exp + SLOTS - 1 - i) % SLOTS;
        end else if (mode >= 2) begin
            for (int i = SLOTS - 1; i > 0; i--) begin
                int j, t;
                lfsr_step();
                j = int'(lfsr) % (i + 1);
                t = order[i]; order[i] = order[j]; order[j] = t;
            end
        end
        for (int i = 0; i < SLOTS; i++) begin
            chk("R5 ok before fill", 32'(drain_ok), 32'(done[rd_exp]));
            fill_en   = 1'b1;
            fill_tag  = 4'(order[i]);
            fill_data = val_of(rnd, order[i]);
            tick();
            done[order[i]] = 1'b1;
            chk("R4 head ready", 32'(drain_ok), 32'(done[rd_exp]));
        end
        for (int i = 0; i < SLOTS; i++) begin
            chk("R5 ok", 32'(drain_ok), 32'd1);
            chk("R6 order", drain_data, val_of(rnd, rd_exp));
            drain_req = 1'b1;
            tick();
            rd_exp = (rd_exp + 1) % SLOTS;
            if (i == 0) chk("R7 slot freed", 32'(alloc_ok), 32'd1);
        end
        chk("R7 empty", 32'(drain_ok), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        alloc_req = 1'b0; fill_en = 1'b0; drain_req = 1'b0;
        fill_tag = '0; fill_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R1 alloc_ok", 32'(alloc_ok), 32'd1);
        chk("R1 drain_ok", 32'(drain_ok), 32'd0);
        chk("R1 tag", 32'(alloc_tag), 32'd0);

        for (int r = 0; r < 8; r++) run_round(r, (r < 3) ? r : 2);

        // R8: paired allocation and drain at the near-full point
        for (int i = 0; i < SLOTS - 1; i++) begin
            alloc_req = 1'b1;
            tick();
            wr_exp = (wr_exp + 1) % SLOTS;
        end
        fill_en = 1'b1; fill_tag = 4'(rd_exp); fill_data = val_of(40, rd_exp);
        tick();
        alloc_req = 1'b1; drain_req = 1'b1;
        #1;
        chk("R8 paired data", drain_data, val_of(40, rd_exp));
        chk("R8 paired tag", 32'(alloc_tag), 32'(wr_exp));
        tick();
        wr_exp = (wr_exp + 1) % SLOTS;
        rd_exp = (rd_exp + 1) % SLOTS;
        chk("R8 count held", 32'(alloc_ok), 32'd1);
        alloc_req = 1'b1;
        tick();
        wr_exp = (wr_exp + 1) % SLOTS;
        chk("R8 full after one", 32'(alloc_ok), 32'd0);

        // R9: fill all but the reissued slot, drain up to it
        for (int i = 1; i < SLOTS; i++) begin
            int t;
            t = (rd_exp + SLOTS - i) % SLOTS;
            if (i == SLOTS - 1) t = (rd_exp + SLOTS - 1) % SLOTS;
            fill_en = 1'b1; fill_tag = 4'((rd_exp + i - 1) % SLOTS);
            fill_data = val_of(41, (rd_exp + i - 1) % SLOTS);
            tick();
        end
        for (int i = 0; i < SLOTS - 1; i++) begin
            chk("R6 tail order", drain_data, val_of(41, rd_exp));
            drain_req = 1'b1;
            tick();
            rd_exp = (rd_exp + 1) % SLOTS;
        end
        chk("R9 reissued not ready", 32'(drain_ok), 32'd0);
        fill_en = 1'b1; fill_tag = 4'(rd_exp); fill_data = val_of(42, rd_exp);
        tick();
        chk("R9 refilled ready", 32'(drain_ok), 32'd1);
        chk("R9 fresh data", drain_data, val_of(42, rd_exp));
        drain_req = 1'b1;
        tick();
        chk("R7 drained empty", 32'(drain_ok), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule